// File: doc/BRIEF.md
# Unified Program and Data Memory Controller

This controller sits between a small 8-bit processor and its on-chip storage. It serves three requesters: the instruction fetch unit, a code-read path used for constant table lookups, and an external-data path that can both read and write. Every 16-bit address is decoded to one of three places: a 4608-byte RAM that holds code and data alike, a 12 kB execute-only ROM, or an unmapped hole that answers with zero.

The RAM answers all three requesters, but only the external-data path may write it. The ROM answers instruction fetches only. A table or external-data read that lands in ROM gets a fixed filler byte instead of the ROM contents, and a one-cycle flag marks the attempt. Only one request is served per cycle. When requests collide, the external-data path has priority over table reads, and table reads have priority over fetches. A requester that loses sees its ready output low and keeps its request up. Read data arrives one cycle after the request is accepted.

Top module: `shmem_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `fetch_valid`, `tbl_valid`, `xd_valid` and `prot_err` are 0.
- R2: An accepted fetch from 0x0000–0x2FFF returns the ROM byte, which is addr[7:0] XOR addr[15:8] XOR 0x5A.
- R3: A byte written to RAM (0x3000–0x41FF) through the external-data path is returned by a later read of the same address on any of the three requesters.
- R4: A table read or external-data read in 0x0000–0x2FFF returns 0xFF, never the ROM byte, and raises `prot_err` for exactly the cycle in which that data is valid.
- R5: Reads from 0x4200–0xFFFF return 0x00 and do not raise `prot_err`. Writes to the unmapped range or to ROM change no RAM byte and no ROM byte.
- R6: `xd_ready` is always 1. `tbl_ready` is 0 exactly when `xd_req` is 1. `fetch_ready` is 0 exactly when `xd_req` or `tbl_req` is 1. A requester whose ready is low is not served in that cycle.
- R7: A read that is accepted in cycle t has its valid output high, with its data, in cycle t+1 only. A requester that was not accepted sees no valid output.
- R8: The region edges decode exactly: 0x2FFF is ROM, 0x3000 and 0x41FF are RAM, 0x4200 is unmapped.
- R9: An external-data write (`xd_we` = 1) raises neither `xd_valid` nor `prot_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | 16 | Fetch address |
| fetch_ready | output | 1 | Fetch is accepted in this cycle |
| fetch_valid | output | 1 | Fetch data is valid |
| fetch_data | output | 8 | Fetched byte |
| tbl_req | input | 1 | Code-space table read request |
| tbl_addr | input | 16 | Table read address |
| tbl_ready | output | 1 | Table read is accepted in this cycle |
| tbl_valid | output | 1 | Table read data is valid |
| tbl_data | output | 8 | Table read byte |
| xd_req | input | 1 | External-data request |
| xd_we | input | 1 | 1 = write, 0 = read |
| xd_addr | input | 16 | External-data address |
| xd_wdata | input | 8 | Write byte |
| xd_ready | output | 1 | External-data request is accepted (always 1) |
| xd_valid | output | 1 | External-data read data is valid |
| xd_rdata | output | 8 | External-data read byte |
| prot_err | output | 1 | A data read of ROM was blocked |

## Verification
Ready outputs are combinational, so the bench reads them after a short settle delay in the same cycle that it raises a request. Read data, valid outputs and the protection flag are registered, so each one is sampled at the falling edge after the rising edge that accepts the request, which is exactly one cycle later. A write is effective at its accepting edge. The bench therefore reads the address back in the next request, and an earlier write that was meant to be ignored is checked by reading the affected location later. In the collision test, the bench checks that the losing fetch produces no valid output in the first cycle and its data in the cycle after the winner has been served.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // requester indices, higher index wins arbitration
    localparam int P_FETCH = 0;
    localparam int P_TBL   = 1;
    localparam int P_XD    = 2;
    localparam int N_PORTS = 3;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_ROM  = 2'd1,
        RG_RAM  = 2'd2
    } region_e;
endpackage

// File: rtl/shmem_dec.sv
module shmem_dec
    import shmem_pkg::*;
#(
    parameter int ROM_BASE  = 0,
    parameter int ROM_BYTES = 12288,
    parameter int RAM_BASE  = 12288,
    parameter int RAM_BYTES = 4608,
    localparam int OFF_W    = $clog2(RAM_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [OFF_W-1:0]  ram_off
);
    localparam int ROM_END = ROM_BASE + ROM_BYTES;
    localparam int RAM_END = RAM_BASE + RAM_BYTES;

    logic [ADDR_W:0] a_ext;
    logic [ADDR_W:0] diff;

    always_comb begin
        a_ext = {1'b0, addr};
        diff  = a_ext - (ADDR_W+1)'(RAM_BASE);
        ram_off = diff[OFF_W-1:0];
        if (a_ext >= (ADDR_W+1)'(ROM_BASE) && a_ext < (ADDR_W+1)'(ROM_END)) begin
            region = RG_ROM;
        end else if (a_ext >= (ADDR_W+1)'(RAM_BASE) && a_ext < (ADDR_W+1)'(RAM_END)) begin
            region = RG_RAM;
        end else begin
            region = RG_NONE;
        end
    end

    // R8: a RAM decode always yields an offset inside the array
    always_comb begin
        if (region == RG_RAM) begin
            p_off_in_range_r8: assert (int'(ram_off) < RAM_BYTES)
                else $error("RAM offset out of range");
        end
    end
endmodule

// File: rtl/shmem_arb.sv
module shmem_arb
    import shmem_pkg::*;
#(
    parameter int NP = N_PORTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] grant
);
    logic [NP-1:0] higher;

    // fixed priority: a port is granted only if no higher index requests
    always_comb begin
        higher[NP-1] = 1'b0;
        for (int i = NP-2; i >= 0; i--) begin
            higher[i] = higher[i+1] | req[i+1];
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_grant
        assign grant[g] = req[g] & ~higher[g];
    end

    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_when_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));
endmodule

// File: rtl/shmem_ram.sv
module shmem_ram #(
    parameter int DEPTH = 4608,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[off] <= wdata;
            end else begin
                rdata_q <= mem_q[off];
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
    import shmem_pkg::*;
#(
    parameter int          ROM_BYTES = 12288,
    parameter int          RAM_BASE  = 12288,
    parameter int          RAM_BYTES = 4608,
    parameter logic [7:0]  ROM_SEED  = 8'h5A,
    parameter logic [7:0]  FILL_PROT = 8'hFF,
    parameter logic [7:0]  FILL_NONE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [15:0]       fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_valid,
    output logic [7:0]        fetch_data,
    input  logic              tbl_req,
    input  logic [15:0]       tbl_addr,
    output logic              tbl_ready,
    output logic              tbl_valid,
    output logic [7:0]        tbl_data,
    input  logic              xd_req,
    input  logic              xd_we,
    input  logic [15:0]       xd_addr,
    input  logic [7:0]        xd_wdata,
    output logic              xd_ready,
    output logic              xd_valid,
    output logic [7:0]        xd_rdata,
    output logic              prot_err
);
    localparam int OFF_W = $clog2(RAM_BYTES);

    typedef struct packed {
        logic [N_PORTS-1:0] vld;
        logic               use_ram;
        logic [7:0]         byte_v;
        logic               prot;
    } st_t;

    st_t st_d, st_q;

    logic [N_PORTS-1:0] req, grant;
    logic [ADDR_W-1:0]  sel_addr;
    region_e            region;
    logic [OFF_W-1:0]   ram_off;
    logic               ram_en, ram_we;
    logic [7:0]         ram_rdata;
    logic [7:0]         rd;
    logic               is_write;

    assign req = {xd_req, tbl_req, fetch_req};

    shmem_arb #(.NP(N_PORTS)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant)
    );

    always_comb begin
        if (grant[P_XD]) begin
            sel_addr = xd_addr;
        end else if (grant[P_TBL]) begin
            sel_addr = tbl_addr;
        end else begin
            sel_addr = fetch_addr;
        end
    end

    shmem_dec #(
        .ROM_BASE  (0),
        .ROM_BYTES (ROM_BYTES),
        .RAM_BASE  (RAM_BASE),
        .RAM_BYTES (RAM_BYTES)
    ) u_dec (
        .addr    (sel_addr),
        .region  (region),
        .ram_off (ram_off)
    );

    assign is_write = grant[P_XD] & xd_we;
    assign ram_en   = (|grant) & (region == RG_RAM);
    assign ram_we   = is_write;

    shmem_ram #(.DEPTH(RAM_BYTES), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .off   (ram_off),
        .wdata (xd_wdata),
        .rdata (ram_rdata)
    );

    // next state: who gets data next cycle and where it comes from
    always_comb begin
        st_d         = '0;
        st_d.vld     = is_write ? '0 : grant;
        st_d.use_ram = (region == RG_RAM) && !is_write;
        case (region)
            RG_ROM: begin
                if (grant[P_FETCH]) begin
                    st_d.byte_v = sel_addr[7:0] ^ sel_addr[15:8] ^ ROM_SEED;
                end else begin
                    st_d.byte_v = FILL_PROT;
                    st_d.prot   = (grant[P_TBL] | grant[P_XD]) & !is_write;
                end
            end
            default: st_d.byte_v = FILL_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd          = st_q.use_ram ? ram_rdata : st_q.byte_v;
    assign fetch_ready = grant[P_FETCH] | ~fetch_req & ~xd_req & ~tbl_req;
    assign tbl_ready   = ~xd_req;
    assign xd_ready    = 1'b1;
    assign fetch_valid = st_q.vld[P_FETCH];
    assign tbl_valid   = st_q.vld[P_TBL];
    assign xd_valid    = st_q.vld[P_XD];
    assign fetch_data  = rd;
    assign tbl_data    = rd;
    assign xd_rdata    = rd;
    assign prot_err    = st_q.prot;

    p_fetch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_req || tbl_req) |-> !fetch_ready);
    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready) |=> fetch_valid);
    p_lost_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_ready) |=> !tbl_valid);
    p_prot_filler_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> ((tbl_valid || xd_valid) && rd == FILL_PROT && !fetch_valid));
    p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_req && xd_we) |=> (!xd_valid && !prot_err));
    p_one_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_valid, tbl_valid, xd_valid}));
endmodule

// File: tb/shmem_ctrl_test.sv
module shmem_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0, tbl_req = 1'b0, xd_req = 1'b0, xd_we = 1'b0;
    logic [15:0] fetch_addr = '0, tbl_addr = '0, xd_addr = '0;
    logic [7:0]  xd_wdata = '0;
    logic        fetch_ready, fetch_valid, tbl_ready, tbl_valid;
    logic        xd_ready, xd_valid, prot_err;
    logic [7:0]  fetch_data, tbl_data, xd_rdata;

    int checks = 0;
    int errors = 0;

    shmem_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .tbl_req(tbl_req), .tbl_addr(tbl_addr), .tbl_ready(tbl_ready),
        .tbl_valid(tbl_valid), .tbl_data(tbl_data),
        .xd_req(xd_req), .xd_we(xd_we), .xd_addr(xd_addr), .xd_wdata(xd_wdata),
        .xd_ready(xd_ready), .xd_valid(xd_valid), .xd_rdata(xd_rdata),
        .prot_err(prot_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [1:0]  port;   // 0 fetch, 1 table, 2 external data
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  exp;
        logic        prot;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 1'b1, 16'h3000, 8'hA5, 8'h00, 1'b0}, // R3 write first RAM byte
        '{2'd2, 1'b1, 16'h41FF, 8'h3C, 8'h00, 1'b0}, // R3 write last RAM byte
        '{2'd0, 1'b0, 16'h3000, 8'h00, 8'hA5, 1'b0}, // R3 fetch from RAM
        '{2'd1, 1'b0, 16'h41FF, 8'h00, 8'h3C, 1'b0}, // R3 R8 table read RAM edge
        '{2'd2, 1'b0, 16'h3000, 8'h00, 8'hA5, 1'b0}, // R3 R8 data read RAM base
        '{2'd0, 1'b0, 16'h2FFF, 8'h00, 8'h8A, 1'b0}, // R2 R8 last ROM byte
        '{2'd0, 1'b0, 16'h0000, 8'h00, 8'h5A, 1'b0}, // R2 first ROM byte
        '{2'd1, 1'b0, 16'h0123, 8'h00, 8'hFF, 1'b1}, // R4 table read of ROM
        '{2'd2, 1'b0, 16'h2FFF, 8'h00, 8'hFF, 1'b1}, // R4 data read of ROM
        '{2'd2, 1'b0, 16'h4200, 8'h00, 8'h00, 1'b0}, // R5 R8 first unmapped
        '{2'd2, 1'b1, 16'h4200, 8'h77, 8'h00, 1'b0}, // R5 unmapped write
        '{2'd2, 1'b1, 16'h0010, 8'h99, 8'h00, 1'b0}, // R5 ROM write
        '{2'd0, 1'b0, 16'h0010, 8'h00, 8'h4A, 1'b0}, // R5 ROM unchanged
        '{2'd2, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b0}, // R5 top of space
        '{2'd0, 1'b0, 16'h4200, 8'h00, 8'h00, 1'b0}, // R5 fetch unmapped
        '{2'd1, 1'b0, 16'h3000, 8'h00, 8'hA5, 1'b0}, // R5 RAM untouched
        '{2'd2, 1'b0, 16'h41FF, 8'h00, 8'h3C, 1'b0}  // R5 RAM untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fetch_req = 1'b0; tbl_req = 1'b0; xd_req = 1'b0; xd_we = 1'b0;
    endtask

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 fetch_valid", fetch_valid, 0);
        check("R1 xd_valid", xd_valid, 0);
        check("R1 prot_err", prot_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tbl_valid", tbl_valid, 0);
        check("R6 xd_ready", xd_ready, 1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            case (v.port)
                2'd0: begin fetch_req = 1'b1; fetch_addr = v.addr; end
                2'd1: begin tbl_req = 1'b1; tbl_addr = v.addr; end
                default: begin
                    xd_req = 1'b1; xd_we = v.we; xd_addr = v.addr; xd_wdata = v.wd;
                end
            endcase
            @(posedge clk);
            @(negedge clk);
            idle();
            if (v.we) begin
                check($sformatf("R9 no valid on write v%0d", i), xd_valid, 0);
                check($sformatf("R9 no prot on write v%0d", i), prot_err, 0);
            end else begin
                case (v.port)
                    2'd0: begin
                        check($sformatf("R7 fetch valid v%0d", i), fetch_valid, 1);
                        check($sformatf("R2 R3 fetch data v%0d", i), fetch_data, v.exp);
                    end
                    2'd1: begin
                        check($sformatf("R7 table valid v%0d", i), tbl_valid, 1);
                        check($sformatf("R3 R4 table data v%0d", i), tbl_data, v.exp);
                    end
                    default: begin
                        check($sformatf("R7 data valid v%0d", i), xd_valid, 1);
                        check($sformatf("R3 R5 data read v%0d", i), xd_rdata, v.exp);
                    end
                endcase
                check($sformatf("R4 R5 prot flag v%0d", i), prot_err, v.prot);
            end
            @(negedge clk);
            check($sformatf("R7 valid gone v%0d", i),
                  {fetch_valid, tbl_valid, xd_valid}, 0);
            check($sformatf("R4 prot gone v%0d", i), prot_err, 0);
        end

        // R2 computed ROM pattern at a mid address
        fetch_req = 1'b1; fetch_addr = 16'h1A7C;
        @(posedge clk); @(negedge clk); idle();
        check("R2 mid ROM fetch", fetch_data, rom_byte(16'h1A7C));

        // R6 R7 collision: data wins, fetch held, fetch served next cycle
        fetch_req = 1'b1; fetch_addr = 16'h0200;
        xd_req = 1'b1; xd_we = 1'b0; xd_addr = 16'h41FF;
        #1;
        check("R6 fetch_ready low on collision", fetch_ready, 0);
        check("R6 xd_ready high", xd_ready, 1);
        @(posedge clk); @(negedge clk);
        xd_req = 1'b0;
        check("R6 xd served first", xd_valid, 1);
        check("R6 xd data", xd_rdata, 8'h3C);
        check("R7 held fetch has no valid", fetch_valid, 0);
        #1;
        check("R6 fetch_ready after release", fetch_ready, 1);
        @(posedge clk); @(negedge clk); idle();
        check("R6 held fetch served", fetch_valid, 1);
        check("R6 held fetch data", fetch_data, rom_byte(16'h0200));

        // R6 table loses to data, beats fetch
        tbl_req = 1'b1; tbl_addr = 16'h3000;
        fetch_req = 1'b1; fetch_addr = 16'h3000;
        xd_req = 1'b1; xd_we = 1'b1; xd_addr = 16'h3001; xd_wdata = 8'h5E;
        #1;
        check("R6 tbl_ready low with data req", tbl_ready, 0);
        check("R6 fetch_ready low with all req", fetch_ready, 0);
        @(posedge clk); @(negedge clk);
        xd_req = 1'b0; xd_we = 1'b0;
        check("R9 write gives no valid", {fetch_valid, tbl_valid, xd_valid}, 0);
        #1;
        check("R6 tbl_ready after data done", tbl_ready, 1);
        check("R6 fetch still held by table", fetch_ready, 0);
        @(posedge clk); @(negedge clk);
        tbl_req = 1'b0;
        check("R6 table served", tbl_valid, 1);
        check("R3 table data", tbl_data, 8'hA5);
        @(posedge clk); @(negedge clk); idle();
        check("R6 fetch served last", fetch_valid, 1);
        tbl_req = 1'b1; tbl_addr = 16'h3001;
        @(posedge clk); @(negedge clk); idle();
        check("R3 written neighbour", tbl_data, 8'h5E);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule